// File: doc/BRIEF.md
# Parallel Host Port Handshake

This block is the host-side parallel port of a scanner-decoder. A single 8-bit bidirectional bus carries traffic in both directions: decoded characters go out to the host, and command characters come in from it. Each direction has its own pair of active-low four-phase strobes. The host requests and the reader acknowledges. Every byte on the bus is a 7-bit ASCII character in bits 6:0, with bit 7 set so that the byte holds an odd number of ones.

Outgoing characters come from the message generator through a one-entry holding register (`tx_valid`/`tx_ready`). When the host asks for data, the reader drives the byte and strobes its acknowledge. Incoming command characters are latched when the host ends its request. They are handed on with a one-cycle `cmd_valid` pulse and a parity verdict. Command decoding and message building sit outside this block. The pad tristate is controlled by `pbus_oe`. All host strobes and the incoming bus pass through a synchronizer `SYNC_STAGES` deep before the control logic uses them.

Top module: `hp_port`

## Requirements
- R1: During and right after reset, both acknowledges (`rdr_dack_n`, `rdr_cack_n`) are high, `pbus_oe` is low, `cmd_valid` and `perr_sticky` are low, and `tx_ready` is high.
- R2: An outgoing byte appears on `pbus_o` as {odd-parity bit, character}, with bit 7 = 1 exactly when character bits 6:0 hold an even number of ones. `pbus_oe` is high at least one cycle before `rdr_dack_n` falls, and `pbus_o` is stable while driven.
- R3: `rdr_dack_n` falls only after the host has lowered `host_dreq_n`. It stays low until the host raises `host_dreq_n`, and then it rises.
- R4: After `rdr_dack_n` rises, the bus stays driven with the same byte for exactly `HOLD_CYC` cycles and is then released (`pbus_oe` low).
- R5: `pbus_oe` is low whenever no outgoing transfer is in progress, and it is never high while `rdr_cack_n` is low.
- R6: `rdr_cack_n` falls after the host lowers `host_creq_n` and rises after the host raises it. At that moment `cmd_valid` pulses for exactly one cycle, with `cmd_char` equal to bits 6:0 of the bus as presented by the host.
- R7: A command byte with an even number of ones is still delivered, with `cmd_perr` high alongside `cmd_valid`. It also sets `perr_sticky`, which stays high until reset, including across later good bytes. A good byte gives `cmd_perr` low.
- R8: If a command request and a data request are both pending while the port is idle, the command is served first. The data acknowledge and the bus drive wait until the command handshake has completed.
- R9: While a character is held (`tx_ready` low), a further `tx_valid` is ignored. The next transfer carries the first character, and `tx_ready` returns high once that transfer finishes.
- R10: A held character is not driven while `host_dreq_n` stays high. `pbus_oe` stays low and `rdr_dack_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Outgoing character offered |
| tx_char | input | 7 | Outgoing ASCII character |
| tx_ready | output | 1 | Holding register empty |
| cmd_valid | output | 1 | One-cycle pulse: command character received |
| cmd_char | output | 7 | Received command character |
| cmd_perr | output | 1 | Parity error on the received byte, valid with cmd_valid |
| perr_sticky | output | 1 | Any parity error since reset |
| host_dreq_n | input | 1 | Host data request, active low |
| rdr_dack_n | output | 1 | Reader data acknowledge, active low |
| host_creq_n | input | 1 | Host command request, active low |
| rdr_cack_n | output | 1 | Reader command acknowledge, active low |
| pbus_i | input | 8 | Bus value seen at the pad |
| pbus_o | output | 8 | Bus value driven by the reader |
| pbus_oe | output | 1 | Reader drives the bus when high |

## Verification
Outgoing transfers use characters with an even count of ones and with an odd count. This shows that bit 7 really tracks parity and is not a constant. Commands use a correctly coded byte, a byte with the wrong parity, and then a good byte. This separates the per-byte flag from the sticky one. Two timing patterns test the arbitration: both requests lowered together, where the command must win, and a held byte with no host request, where nothing may be driven. A second offer during a held byte shows whether the register holds or is overwritten.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [1:0] {
        D_IDLE,
        D_SETUP,
        D_ACK,
        D_HOLD
    } dstate_e;

    typedef enum logic {
        C_IDLE,
        C_ACK
    } cstate_e;

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hp_parity.sv
module hp_parity #(
    parameter int CHAR_W = 7
) (
    input  logic [CHAR_W-1:0] gen_char,
    output logic              gen_bit,
    input  logic [CHAR_W:0]   chk_byte,
    output logic              chk_ok
);
    // odd parity: the whole byte carries an odd number of ones
    assign gen_bit = ~^gen_char;
    assign chk_ok  = ^chk_byte;
endmodule

// File: rtl/hp_port.sv
module hp_port
    import hp_pkg::*;
#(
    parameter int CHAR_W      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [CHAR_W-1:0] tx_char,
    output logic              tx_ready,
    output logic              cmd_valid,
    output logic [CHAR_W-1:0] cmd_char,
    output logic              cmd_perr,
    output logic              perr_sticky,
    input  logic              host_dreq_n,
    output logic              rdr_dack_n,
    input  logic              host_creq_n,
    output logic              rdr_cack_n,
    input  logic [CHAR_W:0]   pbus_i,
    output logic [CHAR_W:0]   pbus_o,
    output logic              pbus_oe
);
    localparam int BYTE_W = CHAR_W + 1;
    localparam int SW     = BYTE_W + 2;
    localparam int HCW    = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        dstate_e           dst;
        cstate_e           cst;
        logic [HCW-1:0]    hold_cnt;
        logic              have;
        logic [BYTE_W-1:0] txbyte;
        logic              oe;
        logic              dack_n;
        logic              cack_n;
        logic              cvalid;
        logic [CHAR_W-1:0] cchar;
        logic              cperr;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic [SW-1:0]     sync_out;
    logic              dreq_s_n, creq_s_n;
    logic [BYTE_W-1:0] bus_s;
    logic              par_bit, par_ok;

    hp_sync #(
        .W      (SW),
        .STAGES (SYNC_STAGES),
        .RST_VAL({2'b11, {BYTE_W{1'b0}}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({host_dreq_n, host_creq_n, pbus_i}),
        .q    (sync_out)
    );

    assign dreq_s_n = sync_out[SW-1];
    assign creq_s_n = sync_out[SW-2];
    assign bus_s    = sync_out[BYTE_W-1:0];

    hp_parity #(.CHAR_W(CHAR_W)) u_par (
        .gen_char(tx_char),
        .gen_bit (par_bit),
        .chk_byte(bus_s),
        .chk_ok  (par_ok)
    );

    always_comb begin
        r_d        = r_q;
        r_d.cvalid = 1'b0;

        // holding register load
        if (tx_valid && !r_q.have) begin
            r_d.have   = 1'b1;
            r_d.txbyte = {par_bit, tx_char};
        end

        // command handshake: wins whenever the data side is idle
        case (r_q.cst)
            C_IDLE: begin
                if (!creq_s_n && r_q.dst == D_IDLE) begin
                    r_d.cst    = C_ACK;
                    r_d.cack_n = 1'b0;
                end
            end
            C_ACK: begin
                if (creq_s_n) begin
                    r_d.cst    = C_IDLE;
                    r_d.cack_n = 1'b1;
                    r_d.cvalid = 1'b1;
                    r_d.cchar  = bus_s[CHAR_W-1:0];
                    r_d.cperr  = !par_ok;
                    if (!par_ok) r_d.err = 1'b1;
                end
            end
            default: r_d.cst = C_IDLE;
        endcase

        // data handshake
        case (r_q.dst)
            D_IDLE: begin
                if (r_q.have && !dreq_s_n && creq_s_n && r_q.cst == C_IDLE) begin
                    r_d.dst = D_SETUP;
                    r_d.oe  = 1'b1;
                end
            end
            D_SETUP: begin
                r_d.dst    = D_ACK;
                r_d.dack_n = 1'b0;
            end
            D_ACK: begin
                if (dreq_s_n) begin
                    r_d.dst      = D_HOLD;
                    r_d.dack_n   = 1'b1;
                    r_d.hold_cnt = '0;
                end
            end
            D_HOLD: begin
                if (r_q.hold_cnt == HCW'(HOLD_CYC - 1)) begin
                    r_d.dst  = D_IDLE;
                    r_d.oe   = 1'b0;
                    r_d.have = 1'b0;
                end else begin
                    r_d.hold_cnt = r_q.hold_cnt + 1'b1;
                end
            end
            default: r_d.dst = D_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.dst    <= D_IDLE;
            r_q.cst    <= C_IDLE;
            r_q.dack_n <= 1'b1;
            r_q.cack_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_ready    = !r_q.have;
    assign cmd_valid   = r_q.cvalid;
    assign cmd_char    = r_q.cchar;
    assign cmd_perr    = r_q.cperr;
    assign perr_sticky = r_q.err;
    assign rdr_dack_n  = r_q.dack_n;
    assign rdr_cack_n  = r_q.cack_n;
    assign pbus_o      = r_q.txbyte;
    assign pbus_oe     = r_q.oe;
endmodule

// File: rtl/hp_port_chk.sv
module hp_port_chk #(
    parameter int CHAR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_ready,
    input logic              cmd_valid,
    input logic              perr_sticky,
    input logic              host_dreq_n,
    input logic              rdr_dack_n,
    input logic              host_creq_n,
    input logic              rdr_cack_n,
    input logic [CHAR_W:0]   pbus_o,
    input logic              pbus_oe
);
    assert_bus_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pbus_oe && !rdr_cack_n));

    assert_oe_before_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdr_dack_n) |-> $past(pbus_oe));

    assert_bus_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pbus_oe && $past(pbus_oe)) |-> $stable(pbus_o));

    assert_dack_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdr_dack_n) |-> !$past(host_dreq_n));

    assert_dack_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdr_dack_n) |-> $past(host_dreq_n));

    assert_cack_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdr_cack_n) |-> !$past(host_creq_n));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        perr_sticky |=> perr_sticky);

    assert_drive_needs_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_oe |-> !tx_ready);
endmodule

bind hp_port hp_port_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_ready   (tx_ready),
    .cmd_valid  (cmd_valid),
    .perr_sticky(perr_sticky),
    .host_dreq_n(host_dreq_n),
    .rdr_dack_n (rdr_dack_n),
    .host_creq_n(host_creq_n),
    .rdr_cack_n (rdr_cack_n),
    .pbus_o     (pbus_o),
    .pbus_oe    (pbus_oe)
);

// File: tb/test_hp_port.sv
module test_hp_port;
    localparam int CW   = 7;
    localparam int HOLD = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_valid = 1'b0;
    logic [CW-1:0] tx_char = '0;
    logic          tx_ready, cmd_valid, cmd_perr, perr_sticky;
    logic [CW-1:0] cmd_char;
    logic          host_dreq_n = 1'b1, host_creq_n = 1'b1;
    logic          rdr_dack_n, rdr_cack_n;
    logic [CW:0]   pbus_i = '0;
    logic [CW:0]   pbus_o;
    logic          pbus_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    hp_port #(.CHAR_W(CW), .SYNC_STAGES(2), .HOLD_CYC(HOLD)) i_hp_port (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_char(tx_char), .tx_ready(tx_ready),
        .cmd_valid(cmd_valid), .cmd_char(cmd_char), .cmd_perr(cmd_perr),
        .perr_sticky(perr_sticky),
        .host_dreq_n(host_dreq_n), .rdr_dack_n(rdr_dack_n),
        .host_creq_n(host_creq_n), .rdr_cack_n(rdr_cack_n),
        .pbus_i(pbus_i), .pbus_o(pbus_o), .pbus_oe(pbus_oe)
    );

    function automatic logic [CW:0] odd_byte(input logic [CW-1:0] c);
        return {~^c, c};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic offer(input logic [CW-1:0] c);
        tx_char  = c;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // host reads one byte, checks value, acknowledge order and hold window
    task automatic host_read(input logic [CW-1:0] c, input string req);
        int n;
        host_dreq_n = 1'b0;
        n = 0;
        while (rdr_dack_n && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(!rdr_dack_n, "R3", "dack low after request", rdr_dack_n, 0);
        check(pbus_o == odd_byte(c), req, "bus byte", pbus_o, odd_byte(c));
        check(pbus_oe, "R2", "oe during ack", pbus_oe, 1);
        cyc(4);
        check(!rdr_dack_n, "R3", "dack held while request low", rdr_dack_n, 0);
        host_dreq_n = 1'b1;
        n = 0;
        while (!rdr_dack_n && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(rdr_dack_n, "R3", "dack high after release", rdr_dack_n, 1);
        n = 0;
        while (pbus_oe && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(n == HOLD, "R4", "driven cycles after dack rise", n, HOLD);
        check(!pbus_oe, "R5", "bus released", pbus_oe, 0);
    endtask

    // host writes one command byte
    task automatic host_cmd(input logic [CW:0] b, input bit exp_err, input string req);
        int n;
        bit seen;
        pbus_i      = b;
        host_creq_n = 1'b0;
        n = 0;
        while (rdr_cack_n && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(!rdr_cack_n, "R6", "cack low after request", rdr_cack_n, 0);
        check(!pbus_oe, "R5", "no drive during command", pbus_oe, 0);
        cyc(2);
        host_creq_n = 1'b1;
        seen = 0;
        n = 0;
        while (!seen && n < 50) begin
            @(negedge clk);
            n++;
            if (cmd_valid) begin
                seen = 1;
                check(cmd_char == b[CW-1:0], req, "cmd char", cmd_char, b[CW-1:0]);
                check(cmd_perr == exp_err, "R7", "cmd parity flag", cmd_perr, exp_err);
                check(rdr_cack_n, "R6", "cack high at delivery", rdr_cack_n, 1);
            end
        end
        check(seen, "R6", "cmd_valid seen", seen, 1);
        @(negedge clk);
        check(!cmd_valid, "R6", "cmd_valid one cycle", cmd_valid, 0);
        cyc(2);
        pbus_i = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(3);
        check(rdr_dack_n && rdr_cack_n, "R1", "acks in reset", {rdr_dack_n, rdr_cack_n}, 3);
        check(!pbus_oe && tx_ready, "R1", "oe/ready in reset", {pbus_oe, tx_ready}, 1);
        rst_n = 1'b1;
        cyc(2);
        check(!cmd_valid && !perr_sticky, "R1", "flags after reset",
              {cmd_valid, perr_sticky}, 0);
        check(rdr_dack_n && rdr_cack_n && !pbus_oe, "R1", "idle after reset",
              {rdr_dack_n, rdr_cack_n, pbus_oe}, 6);
    endtask

    task automatic t_output();
        offer(7'h41);   // two ones: parity bit set
        host_read(7'h41, "R2");
        offer(7'h43);   // three ones: parity bit clear
        host_read(7'h43, "R2");
        check(tx_ready, "R9", "ready after transfer", tx_ready, 1);
    endtask

    task automatic t_no_request();
        offer(7'h0D);
        cyc(20);
        check(!pbus_oe, "R10", "no drive without request", pbus_oe, 0);
        check(rdr_dack_n, "R10", "no ack without request", rdr_dack_n, 1);
        host_read(7'h0D, "R10");
    endtask

    task automatic t_ignore_second();
        offer(7'h31);
        check(!tx_ready, "R9", "ready low when held", tx_ready, 0);
        offer(7'h32);
        host_read(7'h31, "R9");
        check(tx_ready, "R9", "ready back", tx_ready, 1);
    endtask

    task automatic t_commands();
        host_cmd(odd_byte(7'h45), 1'b0, "R6");
        check(!perr_sticky, "R7", "sticky clear after good byte", perr_sticky, 0);
        host_cmd({^7'h45, 7'h45}, 1'b1, "R7");
        check(perr_sticky, "R7", "sticky set", perr_sticky, 1);
        host_cmd(odd_byte(7'h2A), 1'b0, "R7");
        check(perr_sticky, "R7", "sticky holds", perr_sticky, 1);
    endtask

    task automatic t_priority();
        int n;
        offer(7'h55);
        pbus_i      = odd_byte(7'h5A);
        host_dreq_n = 1'b0;
        host_creq_n = 1'b0;
        n = 0;
        while (rdr_cack_n && rdr_dack_n && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(!rdr_cack_n, "R8", "command acked first", rdr_cack_n, 0);
        check(rdr_dack_n && !pbus_oe, "R8", "data waits", {rdr_dack_n, pbus_oe}, 2);
        cyc(6);
        check(rdr_dack_n && !pbus_oe, "R8", "data still waits", {rdr_dack_n, pbus_oe}, 2);
        host_creq_n = 1'b1;
        n = 0;
        while (!cmd_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(cmd_char == 7'h5A, "R8", "command delivered", cmd_char, 7'h5A);
        pbus_i = '0;
        host_read(7'h55, "R8");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_output();
        t_no_request();
        t_ignore_second();
        t_commands();
        t_priority();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule